// File: doc/BRIEF.md
# Time-Base Timer Facility

This block keeps a free-running 64-bit time base and builds three timer functions on top of it. A 32-bit interval counter is armed by writing a delay value. It counts down once per time-base increment and raises an interrupt when it reaches zero. If auto-reload is on, it then starts again from the last delay written.

A fixed-interval source raises an interrupt whenever a chosen time-base bit goes from 0 to 1. A watchdog watches another chosen bit and, on its 0-to-1 change, asserts a reset request together with a software-chosen reset-type code. The time base itself never raises an event.

Software uses a small register port with a write side and a separate combinational read side. It loads the delay, picks the watched bits, sets the enables and clears the sticky status with write-one-to-clear. The time base only moves on cycles where the increment input is high, so every timing in the block is in increments, not clocks.

Top module: `timebase_timers`

## Requirements
- R1: The 64-bit time base resets to zero and grows by one on each clock with `tbInc` high, and holds otherwise. Its low word reads at address 3 and its high word at address 4.
- R2: Writing address 0 loads the interval counter and the reload value with `wrData`. On each `tbInc` cycle without such a write, a nonzero counter drops by one. Address 0 reads the current count.
- R3: When the counter steps from 1 on an increment, status bit 0 sets. `pitIrq` equals status bit 0 AND control bit 0.
- R4: With control bit 1 (auto-reload) set, the step from 1 loads the last delay written instead of zero, so expiry repeats every delay increments.
- R5: With auto-reload clear, the counter stays at zero after expiry and raises no further events.
- R6: Writing a delay of zero leaves the counter idle at zero and sets no status.
- R7: Status bit 1 sets on an increment that takes time-base bit FP[s] from 0 to 1. Here s is control bits 4:3 and FP = {4,6,8,10} by default. `fitIrq` equals status bit 1 AND control bit 2.
- R8: Status bit 2 sets on an increment that takes time-base bit WP[s] from 0 to 1. Here s is control bits 7:6 and WP = {10,12,14,16} by default. `wdResetReq` equals status bit 2 AND control bit 5, and `wdResetType` shows control bits 9:8.
- R9: Status bits are sticky. Writing address 2 with a 1 in a bit position clears that bit, but an event in the same cycle wins over the clear. Address 2 reads the status, and address 1 reads back the control bits.
- R10: After reset, every register, output and read value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbInc | input | 1 | Time-base increment enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data (combinational) |
| pitIrq | output | 1 | Interval-timer interrupt |
| fitIrq | output | 1 | Fixed-interval interrupt |
| wdResetReq | output | 1 | Watchdog reset request |
| wdResetType | output | 2 | Requested reset type |

## Verification
The assertions assume that `rst` is applied synchronously, and that `wrEn`, `wrAddr` and `wrData` are stable across the sampling edge. Auto-reload checks also assume the reload value only changes through a delay write. The stimulus changes every input half a cycle away from the active edge. It uses only addresses 0 to 4 for writes and paces `tbInc` in three fixed patterns, so every step of the counter and time base has a known cycle.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DELAY  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] A_TBLO   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TBHI   = 3'd4;

  typedef struct packed {
    logic       loadDelay;
    logic       autoReload;
    logic [1:0] fitSel;
    logic [1:0] wdSel;
  } tbtCmd_t;

  typedef struct packed {
    logic pitExpire;
    logic fitRise;
    logic wdRise;
  } tbtEvt_t;
endpackage

// File: rtl/tbt_datapath.sv
module tbt_datapath
  import tbt_pkg::*;
#(
  parameter int TB_W = 64,
  parameter int CNT_W = 32,
  parameter int FIT_POS [4] = '{4, 6, 8, 10},
  parameter int WD_POS [4] = '{10, 12, 14, 16}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbInc,
  input  tbtCmd_t          cmd,
  input  logic [CNT_W-1:0] delayVal,
  output logic [TB_W-1:0]  timeBase,
  output logic [CNT_W-1:0] count,
  output tbtEvt_t          evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [TB_W-1:0]  tbNext;
  logic [CNT_W-1:0] reloadVal;
  logic [3:0]       fitCand, wdCand;
  logic             atOne;

  assign tbNext = timeBase + TB_W'(1);
  assign atOne  = (count == ONE);

  for (genvar g = 0; g < 4; g++) begin : g_edge
    assign fitCand[g] = ~timeBase[FIT_POS[g]] & tbNext[FIT_POS[g]];
    assign wdCand[g]  = ~timeBase[WD_POS[g]] & tbNext[WD_POS[g]];
  end

  always_comb begin
    evt.pitExpire = tbInc && !cmd.loadDelay && atOne;
    evt.fitRise   = tbInc && fitCand[cmd.fitSel];
    evt.wdRise    = tbInc && wdCand[cmd.wdSel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeBase <= '0;
    end else if (tbInc) begin
      timeBase <= tbNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      reloadVal <= '0;
    end else if (cmd.loadDelay) begin
      count     <= delayVal;
      reloadVal <= delayVal;
    end else if (tbInc && count != '0) begin
      if (atOne) count <= cmd.autoReload ? reloadVal : '0;
      else       count <= count - ONE;
    end
  end

  AST_TB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tbInc |=> timeBase == $past(timeBase)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tbInc && !cmd.loadDelay && count > ONE) |=> count == $past(count) - ONE); // R2
  AST_ZERO_STAY: assert property (@(posedge clk) disable iff (rst)
    (!cmd.loadDelay && count == '0) |=> count == '0); // R6
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (evt.pitExpire && !cmd.autoReload) |=> count == '0); // R5
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (evt.pitExpire && cmd.autoReload) |=> count == reloadVal); // R4
endmodule

// File: rtl/tbt_ctrl.sv
module tbt_ctrl
  import tbt_pkg::*;
#(
  parameter int TB_W = 64,
  parameter int CNT_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  tbtEvt_t           evt,
  input  logic [CNT_W-1:0]  count,
  input  logic [TB_W-1:0]   timeBase,
  output tbtCmd_t           cmd,
  output logic [CNT_W-1:0]  delayVal,
  output logic              pitIrq,
  output logic              fitIrq,
  output logic              wdResetReq,
  output logic [1:0]        wdResetType
);
  localparam int CTRL_W = 10;
  localparam int ST_W = 3;

  logic [CTRL_W-1:0] ctrlReg;
  logic [ST_W-1:0]   statusReg, statusSet, statusClr;

  assign cmd.loadDelay  = wrEn && wrAddr == A_DELAY;
  assign cmd.autoReload = ctrlReg[1];
  assign cmd.fitSel     = ctrlReg[4:3];
  assign cmd.wdSel      = ctrlReg[7:6];
  assign delayVal       = wrData[CNT_W-1:0];

  assign statusSet = {evt.wdRise, evt.fitRise, evt.pitExpire};
  assign statusClr = (wrEn && wrAddr == A_STATUS) ? wrData[ST_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg   <= '0;
      statusReg <= '0;
    end else begin
      if (wrEn && wrAddr == A_CTRL) ctrlReg <= wrData[CTRL_W-1:0];
      statusReg <= (statusReg & ~statusClr) | statusSet;
    end
  end

  assign pitIrq      = statusReg[0] & ctrlReg[0];
  assign fitIrq      = statusReg[1] & ctrlReg[2];
  assign wdResetReq  = statusReg[2] & ctrlReg[5];
  assign wdResetType = ctrlReg[9:8];

  always_comb begin
    unique case (rdAddr)
      A_DELAY:  rdData = DATA_W'(count);
      A_CTRL:   rdData = DATA_W'(ctrlReg);
      A_STATUS: rdData = DATA_W'(statusReg);
      A_TBLO:   rdData = timeBase[DATA_W-1:0];
      A_TBHI:   rdData = timeBase[TB_W-1:DATA_W];
      default:  rdData = '0;
    endcase
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (statusReg[0] && !statusClr[0]) |=> statusReg[0]); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    evt.pitExpire |=> statusReg[0]); // R3
  AST_FIT_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(statusReg[1]) |-> $past(evt.fitRise)); // R7
  AST_WD_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(statusReg[2]) |-> $past(evt.wdRise)); // R8
endmodule

// File: rtl/timebase_timers.sv
module timebase_timers
  import tbt_pkg::*;
#(
  parameter int TB_W = 64,
  parameter int CNT_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbInc,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              pitIrq,
  output logic              fitIrq,
  output logic              wdResetReq,
  output logic [1:0]        wdResetType
);
  tbtCmd_t          cmd;
  tbtEvt_t          evt;
  logic [CNT_W-1:0] delayVal, count;
  logic [TB_W-1:0]  timeBase;

  tbt_datapath #(.TB_W(TB_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .tbInc(tbInc), .cmd(cmd), .delayVal(delayVal),
    .timeBase(timeBase), .count(count), .evt(evt)
  );

  tbt_ctrl #(.TB_W(TB_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evt(evt), .count(count),
    .timeBase(timeBase), .cmd(cmd), .delayVal(delayVal), .pitIrq(pitIrq),
    .fitIrq(fitIrq), .wdResetReq(wdResetReq), .wdResetType(wdResetType)
  );
endmodule

// File: tb/tb_timebase_timers.sv
module tb_timebase_timers;
  logic clk = 0, rst = 1, tbInc = 0, wrEn = 0;
  logic [2:0] wrAddr = 0, rdAddr = 0;
  logic [31:0] wrData = 0, rdData;
  logic pitIrq, fitIrq, wdResetReq;
  logic [1:0] wdResetType;

  int errors = 0, checks = 0, cyc = 0, incMode = 0;
  int pitEvents = 0, wdEvents = 0, fitEvents = 0;
  longint unsigned mTb = 0;
  int unsigned mCnt = 0, mRl = 0;
  bit [9:0] mCtrl = 0;
  bit [2:0] mSt = 0;
  int fitPos [4] = '{4, 6, 8, 10};
  int wdPos [4] = '{10, 12, 14, 16};

  always #10 clk = ~clk;

  timebase_timers dut (.*);

  function automatic bit rises(longint unsigned t, int p);
    longint unsigned n = t + 1;
    return ((t >> p) & 1) == 0 && ((n >> p) & 1) == 1;
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    bit [2:0] set;
    bit [2:0] clr;
    set = 0;
    clr = 0;
    if (rst) begin
      mTb = 0; mCnt = 0; mRl = 0; mCtrl = 0; mSt = 0;
    end else begin
      if (wrEn && wrAddr == 0) begin
        mCnt = wrData; mRl = wrData;
      end else if (tbInc && mCnt != 0) begin
        if (mCnt == 1) begin
          set[0] = 1;
          mCnt = mCtrl[1] ? mRl : 0;
        end else mCnt = mCnt - 1;
      end
      if (tbInc && rises(mTb, fitPos[mCtrl[4:3]])) set[1] = 1;
      if (tbInc && rises(mTb, wdPos[mCtrl[7:6]])) set[2] = 1;
      if (tbInc) mTb = mTb + 1;
      if (wrEn && wrAddr == 2) clr = wrData[2:0];
      mSt = (mSt & ~clr) | set;
      if (wrEn && wrAddr == 1) mCtrl = wrData[9:0];
      if (set[0]) pitEvents++;
      if (set[1]) fitEvents++;
      if (set[2]) wdEvents++;
    end
  end

  function automatic logic [31:0] mRead(logic [2:0] a);
    case (a)
      3'd0: return mCnt;
      3'd1: return {22'd0, mCtrl};
      3'd2: return {29'd0, mSt};
      3'd3: return mTb[31:0];
      3'd4: return mTb[63:32];
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic string readReq(logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1, 3'd2: return "R9";
      default: return "R1";
    endcase
  endfunction

  // compare on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 2) begin
      logic [31:0] e;
      e = mRead(rdAddr);
      check(rdData === e, readReq(rdAddr), rdData, e);
      check(pitIrq === (mSt[0] & mCtrl[0]), "R3", pitIrq, mSt[0] & mCtrl[0]);
      check(fitIrq === (mSt[1] & mCtrl[2]), "R7", fitIrq, mSt[1] & mCtrl[2]);
      check(wdResetReq === (mSt[2] & mCtrl[5]), "R8", wdResetReq, mSt[2] & mCtrl[5]);
      check(wdResetType === mCtrl[9:8], "R8", wdResetType, mCtrl[9:8]);
    end
    #1;
    rdAddr <= 3'(cyc % 5);
    case (incMode)
      0: tbInc <= 1;
      1: tbInc <= (cyc % 2) == 0;
      2: tbInc <= (cyc % 3) == 0;
      default: tbInc <= 0;
    endcase
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #2;
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); #2;
    wrEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin : main
        incMode = 3;
        idle(3);
        #2 rst = 0;
        @(negedge clk);
        check(rdData === 0 && !pitIrq && !fitIrq && !wdResetReq, "R10", rdData, 0); // R10
        // enables on, no auto-reload, fit sel 0, wd sel 0, reset type 2
        wr(1, 32'h225);
        wr(0, 5);
        incMode = 1; idle(30);                    // R2 R3 R5
        check(pitEvents == 1, "R5", pitEvents, 1);
        wr(2, 7); idle(4);                        // R9
        wr(0, 0); idle(20);                       // R6
        check(pitEvents == 1, "R6", pitEvents, 1);
        wr(1, 32'h227);                           // auto-reload on
        wr(0, 3);
        incMode = 2; idle(40);                    // R4
        check(pitEvents >= 3, "R4", pitEvents, 3);
        incMode = 0;
        wr(0, 1);
        repeat (6) wr(2, 1);                      // R9 set wins over clear
        wr(1, 32'h1DD);                           // fit sel 3, wd sel 3
        wr(0, 0);
        wr(2, 7);
        idle(1500);                               // R7
        check(fitEvents > 0, "R7", fitEvents, 1);
        wr(1, 32'h325);                           // wd sel 0, type 3
        idle(2600);                               // R8
        check(wdEvents > 0, "R8", wdEvents, 1);
        incMode = 3; idle(20);                    // R1 hold
      end
      begin : dog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule